// File: doc/BRIEF.md
# Configuration Port Target Model with Serial Command Decoding

This block models the target side of a serial configuration port. A host drives SCLK, MOSI and an active-low select in SPI mode 0. Each select frame opens with one opcode byte and three stuffing bytes. Some opcodes return a 32-bit answer on MISO during the next four bytes. Other opcodes change internal state: the write session, the erase (clear) sequence, the burst-load byte counter and the load-complete flag.

The block is meant for loopback tests of a configuration master. The master can read a parameterised identity word. It can open a write session, start an erase, and poll the status word until the erase has finished, which takes `CLEAR_LAT` system clocks. It then streams a payload and closes the session.

The load-complete flag is raised only in one case. The payload length must match `EXPECT_BYTES`, the payload must have been streamed inside an open session, and the close command must follow it. SPI inputs are oversampled by the system clock, so SCLK must stay well below the system clock rate. The serial link cannot be stalled, so the block has no valid/ready handshake: every byte clocked in is taken.

Top module: `cfg_port_target`

## Requirements
- R1: Opcode 0x07 returns `DEVICE_ID` on MISO, MSB first, during frame bytes 4 to 7. MISO is 0 for any byte after byte 7.
- R2: Opcode 0x09 returns the status word during bytes 4 to 7. Bit 16 means erase complete and bit 14 means load complete. All other bits are 0, so the status word is 0 after reset.
- R3: Opcode 0x70 is ignored while no write session is open. The status word stays 0 and `cleared_o` stays low, even after `CLEAR_LAT` cycles.
- R4: Opcode 0x41 is ignored while no write session is open. `burst_count_o` does not change.
- R5: Opcode 0x4A opens a write session, and `we_o` goes high.
- R6: Opcode 0x70 inside a session starts an erase. The status word reads 0 until `CLEAR_LAT` cycles have passed, and then reads exactly 0x00010000.
- R7: Opcode 0x41 inside a session restarts the counter. Every byte after the three stuffing bytes, up to the rise of select, is counted. The stuffing bytes are never counted. The erase-complete bit drops when the burst starts.
- R8: Opcode 0x4F closes the session (`we_o` low). When a burst of exactly `EXPECT_BYTES` bytes came before it in that session, it raises `done_o`, and the status word then reads 0x00004000.
- R9: A close that follows a burst of any other length leaves `done_o` low.
- R10: An unknown opcode changes no state, and MISO is 0 for the whole frame.
- R11: Opcode 0x71 clears the load-complete and erase-complete flags, cancels a running erase, and leaves the session state unchanged.
- R12: After reset all flags, the counter and MISO are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from host, MSB first |
| spi_miso | output | 1 | Serial reply to host, MSB first |
| we_o | output | 1 | Write session open |
| cleared_o | output | 1 | Erase complete |
| done_o | output | 1 | Load complete |
| burst_count_o | output | CNT_W | Payload bytes counted in the latest burst |

## Verification
The assertions assume two things about the host. First, select stays high through reset and for several system clocks between frames, so MISO has settled to 0 before the idle check applies. Second, each SCLK half period lasts long enough for the synchroniser and the reply load to complete. The bench meets both by using six system clocks per half period and twelve idle clocks after each frame. It also never sends a session-changing command in the same cycle that an erase timer expires.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam logic [7:0] OPC_RD_ID    = 8'h07;
  localparam logic [7:0] OPC_RD_STAT  = 8'h09;
  localparam logic [7:0] OPC_ERASE    = 8'h70;
  localparam logic [7:0] OPC_REFRESH  = 8'h71;
  localparam logic [7:0] OPC_WR_OPEN  = 8'h4A;
  localparam logic [7:0] OPC_WR_CLOSE = 8'h4F;
  localparam logic [7:0] OPC_BURST    = 8'h41;

  localparam int STAT_ERASED_BIT = 16;
  localparam int STAT_LOADED_BIT = 14;

  // byte position 4 means "payload or reply phase" (saturated)
  localparam logic [2:0] POS_LAST_STUFF = 3'd3;
  localparam logic [2:0] POS_BODY       = 3'd4;

  typedef struct packed {
    logic [7:0] dat;
    logic [2:0] pos;
  } rx_byte_t;

  function automatic logic [31:0] status_word(input logic erased, input logic loaded);
    logic [31:0] w;
    w = '0;
    w[STAT_ERASED_BIT] = erased;
    w[STAT_LOADED_BIT] = loaded;
    return w;
  endfunction
endpackage

// File: rtl/cfgp_spi_front.sv
module cfgp_spi_front
  import cfgp_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              byte_vld,
  output rx_byte_t          byte_ev,
  output logic              frame_end,
  input  logic              load_vld,
  input  logic [WORD_W-1:0] load_word
);
  logic [2:0]        s_sclk;
  logic [2:0]        s_cs;
  logic [1:0]        s_mosi;
  logic [2:0]        bit_cnt;
  logic [2:0]        pos;
  logic [7:0]        shin;
  logic              pend;
  logic [WORD_W-1:0] sreg;

  logic rise, fall, cs_act, cs_stop;
  assign rise    = s_sclk[1] & ~s_sclk[2];
  assign fall    = ~s_sclk[1] & s_sclk[2];
  assign cs_act  = ~s_cs[1];
  assign cs_stop = s_cs[1] & ~s_cs[2];
  assign miso    = sreg[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sclk <= '0;
      s_cs   <= '1;
      s_mosi <= '0;
    end else begin
      s_sclk <= {s_sclk[1:0], sclk};
      s_cs   <= {s_cs[1:0], cs_n};
      s_mosi <= {s_mosi[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      pos       <= '0;
      shin      <= '0;
      pend      <= 1'b0;
      sreg      <= '0;
      byte_vld  <= 1'b0;
      byte_ev   <= '0;
      frame_end <= 1'b0;
    end else begin
      byte_vld  <= 1'b0;
      frame_end <= cs_stop;
      if (!cs_act) begin
        bit_cnt <= '0;
        pos     <= '0;
        pend    <= 1'b0;
        sreg    <= '0;
      end else begin
        if (rise) begin
          shin    <= {shin[6:0], s_mosi[1]};
          bit_cnt <= bit_cnt + 3'd1;
          pend    <= (pos == POS_BODY);
          if (bit_cnt == 3'd7) begin
            byte_vld    <= 1'b1;
            byte_ev.dat <= {shin[6:0], s_mosi[1]};
            byte_ev.pos <= pos;
            if (pos != POS_BODY) pos <= pos + 3'd1;
          end
        end
        if (fall && pend) begin
          sreg <= {sreg[WORD_W-2:0], 1'b0};
          pend <= 1'b0;
        end
        if (load_vld) sreg <= load_word;
      end
    end
  end
endmodule

// File: rtl/cfgp_erase_timer.sv
module cfgp_erase_timer #(
  parameter int LATENCY = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic fire
);
  localparam int CW = $clog2(LATENCY + 1);
  localparam logic [CW-1:0] LAST = CW'(LATENCY - 1);

  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
      end else if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        if (cnt == LAST) begin
          busy <= 1'b0;
          fire <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfgp_cmd_ctl.sv
module cfgp_cmd_ctl
  import cfgp_pkg::*;
#(
  parameter logic [31:0] DEVICE_ID    = 32'h5EC0_1D17,
  parameter int          CNT_W        = 16,
  parameter int          EXPECT_BYTES = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  rx_byte_t         byte_ev,
  input  logic             frame_end,
  input  logic             erase_fire,
  output logic             erase_start,
  output logic             erase_abort,
  output logic             load_vld,
  output logic [31:0]      load_word,
  output logic             we_o,
  output logic             cleared_o,
  output logic             done_o,
  output logic [CNT_W-1:0] burst_count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_EXP = CNT_W'(EXPECT_BYTES);

  logic [7:0] opcode;
  logic       burst_on;
  logic       burst_seen;
  logic       cmd_go;

  assign cmd_go      = byte_vld && (byte_ev.pos == POS_LAST_STUFF);
  assign erase_start = cmd_go && (opcode == OPC_ERASE) && we_o;
  assign erase_abort = cmd_go && ((opcode == OPC_REFRESH) || (opcode == OPC_WR_CLOSE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode        <= '0;
      burst_on      <= 1'b0;
      burst_seen    <= 1'b0;
      load_vld      <= 1'b0;
      load_word     <= '0;
      we_o          <= 1'b0;
      cleared_o     <= 1'b0;
      done_o        <= 1'b0;
      burst_count_o <= '0;
    end else begin
      load_vld <= 1'b0;
      if (erase_fire && !erase_abort) cleared_o <= 1'b1;
      if (frame_end) burst_on <= 1'b0;
      if (byte_vld && byte_ev.pos == 3'd0) opcode <= byte_ev.dat;
      if (byte_vld && byte_ev.pos == POS_BODY && burst_on && burst_count_o != CNT_MAX)
        burst_count_o <= burst_count_o + 1'b1;
      if (cmd_go) begin
        unique case (opcode)
          OPC_RD_ID: begin
            load_vld  <= 1'b1;
            load_word <= DEVICE_ID;
          end
          OPC_RD_STAT: begin
            load_vld  <= 1'b1;
            load_word <= status_word(cleared_o, done_o);
          end
          OPC_WR_OPEN: we_o <= 1'b1;
          OPC_REFRESH: begin
            cleared_o <= 1'b0;
            done_o    <= 1'b0;
          end
          OPC_ERASE: if (we_o) begin
            cleared_o  <= 1'b0;
            done_o     <= 1'b0;
            burst_seen <= 1'b0;
          end
          OPC_BURST: if (we_o) begin
            burst_on      <= 1'b1;
            burst_seen    <= 1'b1;
            burst_count_o <= '0;
            cleared_o     <= 1'b0;
            done_o        <= 1'b0;
          end
          OPC_WR_CLOSE: begin
            if (we_o && burst_seen && burst_count_o == CNT_EXP) done_o <= 1'b1;
            we_o       <= 1'b0;
            burst_seen <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_port_target.sv
module cfg_port_target
  import cfgp_pkg::*;
#(
  parameter logic [31:0] DEVICE_ID    = 32'h5EC0_1D17,
  parameter int          CLEAR_LAT    = 2000,
  parameter int          EXPECT_BYTES = 12,
  parameter int          CNT_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  output logic             we_o,
  output logic             cleared_o,
  output logic             done_o,
  output logic [CNT_W-1:0] burst_count_o
);
  localparam int WORD_W = 32;

  logic              byte_vld;
  rx_byte_t          byte_ev;
  logic              frame_end;
  logic              load_vld;
  logic [WORD_W-1:0] load_word;
  logic              erase_start, erase_abort, erase_fire;

  cfgp_spi_front #(.WORD_W(WORD_W)) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .miso      (spi_miso),
    .byte_vld  (byte_vld),
    .byte_ev   (byte_ev),
    .frame_end (frame_end),
    .load_vld  (load_vld),
    .load_word (load_word)
  );

  cfgp_erase_timer #(.LATENCY(CLEAR_LAT)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (erase_start),
    .abort (erase_abort),
    .fire  (erase_fire)
  );

  cfgp_cmd_ctl #(
    .DEVICE_ID    (DEVICE_ID),
    .CNT_W        (CNT_W),
    .EXPECT_BYTES (EXPECT_BYTES)
  ) u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .byte_vld      (byte_vld),
    .byte_ev       (byte_ev),
    .frame_end     (frame_end),
    .erase_fire    (erase_fire),
    .erase_start   (erase_start),
    .erase_abort   (erase_abort),
    .load_vld      (load_vld),
    .load_word     (load_word),
    .we_o          (we_o),
    .cleared_o     (cleared_o),
    .done_o        (done_o),
    .burst_count_o (burst_count_o)
  );
endmodule

// File: rtl/cfg_port_target_chk.sv
module cfg_port_target_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spi_cs_n,
  input logic             spi_miso,
  input logic             we_o,
  input logic             cleared_o,
  input logic             done_o,
  input logic [CNT_W-1:0] burst_count_o
);
  // R8: the load-complete flag rises together with the session closing
  p_done_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !we_o);

  // R8: a finished load never shows erase-complete at the same time
  p_done_not_erased_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !cleared_o);

  // R3: erase completion only happens inside an open session
  p_erase_in_session_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cleared_o) |-> we_o);

  // R4: with no session the byte counter holds
  p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_o |=> $stable(burst_count_o));

  // R10: MISO idles low once select has been high for a few clocks
  p_miso_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso);
endmodule

bind cfg_port_target cfg_port_target_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .spi_cs_n      (spi_cs_n),
  .spi_miso      (spi_miso),
  .we_o          (we_o),
  .cleared_o     (cleared_o),
  .done_o        (done_o),
  .burst_count_o (burst_count_o)
);

// File: tb/cfg_port_target_test.sv
module cfg_port_target_test;
  localparam logic [31:0] ID   = 32'h5EC0_1D17;
  localparam int          LAT  = 2000;
  localparam int          EXPB = 12;
  localparam int          CW   = 16;
  localparam int          HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, we, clr, done;
  logic [CW-1:0] cnt;

  int total = 0, bad = 0;
  logic [31:0] last_word;
  logic [7:0]  last_extra;
  logic [31:0] exp_q[$];
  logic [31:0] act_q[$];
  string       tag_q[$];
  bit          finished = 0;

  always #4 clk = ~clk;

  cfg_port_target #(.DEVICE_ID(ID), .CLEAR_LAT(LAT), .EXPECT_BYTES(EXPB), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .we_o(we), .cleared_o(clr), .done_o(done), .burst_count_o(cnt));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic spi_frame(input logic [7:0] op, input int nbytes, input logic [7:0] fill);
    logic [7:0] tb;
    logic [31:0] w;
    logic [7:0] extra;
    w = '0;
    extra = '0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nbytes; b++) begin
      tb = (b == 0) ? op : (b < 4) ? 8'hA5 : fill;
      for (int k = 7; k >= 0; k--) begin
        sclk = 1'b0;
        mosi = tb[k];
        repeat (HALF) @(negedge clk);
        if (b >= 4 && b < 8) w = {w[30:0], miso};
        else if (b >= 8) extra = extra | {7'b0, miso};
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
      end
    end
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
    last_word = w;
    last_extra = extra;
  endtask

  // driver: push the expected reply, run the frame, hand the reply to the monitor
  task automatic read_expect(input logic [7:0] op, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    spi_frame(op, 8, 8'h00);
    act_q.push_back(last_word);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      while (act_q.size() > 0) begin
        logic [31:0] a, e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(a == e, t, a, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int polls;
    logic [31:0] st;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R12 reset state
    check({miso, we, clr, done} == 4'b0 && cnt == '0, "R12 reset outputs",
          {miso, we, clr, done, cnt}, 32'h0);

    // R1 identity, and zero after byte 7
    read_expect(8'h07, ID, "R1 id word");
    spi_frame(8'h07, 10, 8'h00);
    check(last_extra == 8'h00, "R1 bytes after reply", {24'h0, last_extra}, 32'h0);
    // R2 initial status
    read_expect(8'h09, 32'h0, "R2 status after reset");

    // R3 erase without session
    spi_frame(8'h70, 4, 8'h00);
    repeat (LAT + 50) @(negedge clk);
    check(clr == 1'b0, "R3 cleared_o no session", {31'h0, clr}, 32'h0);
    read_expect(8'h09, 32'h0, "R3 status no session");

    // R4 burst without session
    spi_frame(8'h41, 9, 8'h3C);
    check(cnt == '0, "R4 count no session", {16'h0, cnt}, 32'h0);

    // R10 unknown opcode
    spi_frame(8'h5A, 10, 8'hFF);
    check(last_word == 32'h0 && last_extra == 8'h0, "R10 miso zero", last_word, 32'h0);
    check({we, clr, done} == 3'b0, "R10 state unchanged", {29'h0, we, clr, done}, 32'h0);

    // R5 open session
    spi_frame(8'h4A, 4, 8'h00);
    check(we == 1'b1, "R5 we_o", {31'h0, we}, 32'h1);

    // R6 erase with polling
    spi_frame(8'h70, 4, 8'h00);
    read_expect(8'h09, 32'h0, "R6 status while erasing");
    polls = 1;
    st = 32'h0;
    for (int i = 0; i < 20; i++) begin
      spi_frame(8'h09, 8, 8'h00);
      st = last_word;
      polls++;
      if (st == 32'h0001_0000) break;
    end
    check(st == 32'h0001_0000, "R6 erased status", st, 32'h0001_0000);
    check(polls >= 3, "R6 polls needed", polls, 32'd3);

    // R7 burst inside session
    spi_frame(8'h41, 4 + EXPB, 8'h96);
    check(cnt == CW'(EXPB), "R7 payload count", {16'h0, cnt}, EXPB);
    read_expect(8'h09, 32'h0, "R7 erased bit dropped");

    // R8 close gives load complete
    spi_frame(8'h4F, 4, 8'h00);
    check(done == 1'b1 && we == 1'b0, "R8 done and closed", {30'h0, done, we}, 32'h2);
    read_expect(8'h09, 32'h0000_4000, "R8 status loaded");

    // R11 refresh
    spi_frame(8'h71, 4, 8'h00);
    check(done == 1'b0, "R11 done cleared", {31'h0, done}, 32'h0);
    read_expect(8'h09, 32'h0, "R11 status after refresh");

    // R9 wrong length
    spi_frame(8'h4A, 4, 8'h00);
    spi_frame(8'h41, 4 + EXPB - 5, 8'h11);
    check(cnt == CW'(EXPB - 5), "R9 short count", {16'h0, cnt}, EXPB - 5);
    spi_frame(8'h4F, 4, 8'h00);
    check(done == 1'b0 && we == 1'b0, "R9 no done", {30'h0, done, we}, 32'h0);

    repeat (10) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule